// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Unit

This unit sits in a load/store path and supports atomic read-modify-write sequences with a single address reservation. A load-reserve request reads memory and, once the read returns, records its effective address as the live reservation. A store-conditional request writes memory only if a live reservation matches its effective address. It reports the outcome in a 4-bit condition field, and it drops the reservation whatever the outcome.

Requests arrive on one valid/ready port that carries the operation kind, size (word or doubleword), byte order, address and store data. The unit drives a single outstanding memory request and waits for a one-cycle acknowledge. Memory is big-endian: the byte at the lowest address is the most significant. A word occupies data bits 31:0. A byte-reversed request swaps the bytes of the word or doubleword on the data path. Any request whose address has a nonzero value in bits 1:0 is trapped as an alignment exception before it does anything. A mode input selects 64-bit addressing or 32-bit addressing, in which the upper address half is forced to zero.

Top module: `lrsc_reservation_unit`

## Requirements
- R1: A request accepted with req_addr_i[1:0] != 0, load-reserve or store-conditional, word or doubleword, raises align_exc_o for exactly the one cycle after acceptance. It issues no memory request, gives no ld_valid_o or sc_done_o pulse, and leaves sc_cr_o and the reservation unchanged.
- R2: An aligned load-reserve (req_is_sc_i = 0) issues a read (mem_req_o = 1, mem_we_o = 0) at its effective address. In the cycle after mem_ack_i it pulses ld_valid_o with the read data on ld_data_o and records the address as the reservation.
- R3: An aligned store-conditional (req_is_sc_i = 1) whose effective address equals a live reservation issues a write (mem_we_o = 1). In the cycle after mem_ack_i it pulses sc_done_o with sc_cr_o = {2'b00, 1'b1, so}.
- R4: A store-conditional with no live reservation, or with a different address, issues no write. It pulses sc_done_o in the cycle after acceptance with sc_cr_o = {3'b000, so}.
- R5: Every completed store-conditional invalidates the reservation, so a following store-conditional to the same address fails.
- R6: req_dbl_i = 1 selects 8 bytes and 0 selects 4 bytes in bits 31:0, zero-extended on ld_data_o. req_rev_i = 1 reverses the byte order of the load result and the store data; req_rev_i = 0 passes them big-endian.
- R7: With mode64_i = 0 the effective address is {32'h0, req_addr_i[31:0]}. It is used for mem_addr_o, for the recorded reservation and for the comparison. With mode64_i = 1 all 64 bits are used.
- R8: A second load-reserve replaces the earlier reservation without error: a store-conditional to the old address then fails, and one to the new address succeeds.
- R9: After reset req_ready_o = 1, the pulses and mem_req_o are 0, sc_cr_o = 0 and no reservation is live. req_ready_o is 0 while a memory access is outstanding, and the memory request fields stay stable until mem_ack_i.
- R10: The so bit in sc_cr_o is so_flag_i sampled when the store-conditional is accepted, not when it completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode64_i | input | 1 | 1 = 64-bit addressing, 0 = 32-bit |
| so_flag_i | input | 1 | Summary-overflow bit merged into the condition field |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Unit can accept a request |
| req_is_sc_i | input | 1 | 1 = store-conditional, 0 = load-reserve |
| req_dbl_i | input | 1 | 1 = doubleword, 0 = word |
| req_rev_i | input | 1 | 1 = byte-reversed data |
| req_addr_i | input | 64 | Request address |
| req_wdata_i | input | 64 | Store-conditional data (word in bits 31:0) |
| mem_req_o | output | 1 | Memory access request, held until acknowledge |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_dbl_o | output | 1 | Access size, 1 = 8 bytes |
| mem_addr_o | output | 64 | Memory effective address |
| mem_wdata_o | output | 64 | Write data, big-endian order |
| mem_ack_i | input | 1 | One-cycle memory acknowledge |
| mem_rdata_i | input | 64 | Read data, valid with mem_ack_i |
| ld_valid_o | output | 1 | Load-reserve completion pulse |
| ld_data_o | output | 64 | Load-reserve result |
| align_exc_o | output | 1 | Alignment exception pulse |
| sc_done_o | output | 1 | Store-conditional completion pulse |
| sc_cr_o | output | 4 | Condition field: bit1 success, bit0 so |

## Verification
Store-conditionals are tried after a matching load-reserve, after a load-reserve to another address, straight after reset and straight after another store-conditional. This separates a correct compare from a stuck reservation or one that is not cleared. Address pairs that differ only in the upper half are run in both addressing modes, which exposes a mode-dependent compare that is wrong. Misaligned requests are placed between a load-reserve and its store-conditional, so a trap that disturbs the reservation or the condition field shows up. Random runs cycle through every size and byte-order combination on a small address pool with so_flag_i flipped during the memory access. This checks both the lane steering and when the summary-overflow bit is sampled.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;

  localparam int CR_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_STORE = 2'd2
  } lrsc_state_e;

  // condition field: bit1 = conditional store performed, bit0 = summary overflow
  function automatic logic [CR_W-1:0] make_cr(input logic ok, input logic so);
    return {2'b00, ok, so};
  endfunction

endpackage

// File: rtl/lrsc_byte_lane.sv
module lrsc_byte_lane #(
  parameter int DATA_W = 64
) (
  input  logic              dbl_i,
  input  logic              rev_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NB     = DATA_W / 8;
  localparam int HB     = NB / 2;
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] full_swap;
  logic [HALF_W-1:0] half_swap;

  for (genvar b = 0; b < NB; b++) begin : g_full
    assign full_swap[8*b +: 8] = data_i[8*(NB-1-b) +: 8];
  end

  for (genvar h = 0; h < HB; h++) begin : g_half
    assign half_swap[8*h +: 8] = data_i[8*(HB-1-h) +: 8];
  end

  always_comb begin
    if (dbl_i) begin
      data_o = rev_i ? full_swap : data_i;
    end else begin
      data_o = {{HALF_W{1'b0}}, (rev_i ? half_swap : data_i[HALF_W-1:0])};
    end
  end

endmodule

// File: rtl/lrsc_rsv_reg.sv
module lrsc_rsv_reg #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_set_i,
  input  logic [ADDR_W-1:0] addr_cmp_i,
  output logic              match_o
);
  logic              vld_q, vld_d;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    vld_d = vld_q;
    if (set_i) begin
      vld_d = 1'b1;
    end else if (clr_i) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // address register only loads on a new reservation
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (set_i) begin
      addr_q <= addr_set_i;
    end
  end

  assign match_o = vld_q && (addr_q == addr_cmp_i);

endmodule

// File: rtl/lrsc_ctrl.sv
module lrsc_ctrl
  import lrsc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid_i,
  input  logic            is_sc_i,
  input  logic            misalign_i,
  input  logic            match_i,
  input  logic            so_i,
  input  logic            mem_ack_i,
  output logic            ready_o,
  output logic            accept_o,
  output logic            cap_en_o,
  output logic            mem_req_o,
  output logic            mem_we_o,
  output logic            ld_fire_o,
  output logic            rsv_set_o,
  output logic            rsv_clr_o,
  output logic            align_exc_o,
  output logic            ld_valid_o,
  output logic            sc_done_o,
  output logic [CR_W-1:0] sc_cr_o
);
  lrsc_state_e     state_q, state_d;
  logic            run_q;
  logic            mreq_q, mreq_d;
  logic            we_q, we_d;
  logic            exc_q, exc_d;
  logic            ldv_q, ldv_d;
  logic            done_q, done_d;
  logic            so_q, so_d;
  logic [CR_W-1:0] cr_q, cr_d;

  assign ready_o   = run_q && (state_q == ST_IDLE);
  assign accept_o  = req_valid_i && ready_o;
  assign cap_en_o  = accept_o && !misalign_i;
  assign ld_fire_o = (state_q == ST_LOAD) && mem_ack_i;
  assign rsv_set_o = ld_fire_o;
  assign rsv_clr_o = (cap_en_o && is_sc_i && !match_i) ||
                     ((state_q == ST_STORE) && mem_ack_i);

  always_comb begin
    state_d = state_q;
    mreq_d  = mreq_q;
    we_d    = we_q;
    so_d    = so_q;
    cr_d    = cr_q;
    exc_d   = 1'b0;
    ldv_d   = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept_o) begin
          if (misalign_i) begin
            exc_d = 1'b1;
          end else if (!is_sc_i) begin
            state_d = ST_LOAD;
            mreq_d  = 1'b1;
            we_d    = 1'b0;
          end else if (match_i) begin
            state_d = ST_STORE;
            mreq_d  = 1'b1;
            we_d    = 1'b1;
            so_d    = so_i;
          end else begin
            done_d = 1'b1;
            cr_d   = make_cr(1'b0, so_i);
          end
        end
      end
      ST_LOAD: begin
        if (mem_ack_i) begin
          state_d = ST_IDLE;
          mreq_d  = 1'b0;
          ldv_d   = 1'b1;
        end
      end
      ST_STORE: begin
        if (mem_ack_i) begin
          state_d = ST_IDLE;
          mreq_d  = 1'b0;
          we_d    = 1'b0;
          done_d  = 1'b1;
          cr_d    = make_cr(1'b1, so_q);
        end
      end
      default: begin
        state_d = ST_IDLE;
        mreq_d  = 1'b0;
        we_d    = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
      mreq_q  <= 1'b0;
      we_q    <= 1'b0;
      so_q    <= 1'b0;
      cr_q    <= '0;
      exc_q   <= 1'b0;
      ldv_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
      mreq_q  <= mreq_d;
      we_q    <= we_d;
      so_q    <= so_d;
      cr_q    <= cr_d;
      exc_q   <= exc_d;
      ldv_q   <= ldv_d;
      done_q  <= done_d;
    end
  end

  assign mem_req_o   = mreq_q;
  assign mem_we_o    = we_q;
  assign align_exc_o = exc_q;
  assign ld_valid_o  = ldv_q;
  assign sc_done_o   = done_q;
  assign sc_cr_o     = cr_q;

endmodule

// File: rtl/lrsc_reservation_unit.sv
module lrsc_reservation_unit
  import lrsc_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int DATA_W     = 64,
  parameter int ALIGN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode64_i,
  input  logic              so_flag_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_is_sc_i,
  input  logic              req_dbl_i,
  input  logic              req_rev_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_dbl_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              ld_valid_o,
  output logic [DATA_W-1:0] ld_data_o,
  output logic              align_exc_o,
  output logic              sc_done_o,
  output logic [CR_W-1:0]   sc_cr_o
);
  localparam int ADDR_HALF = ADDR_W / 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[1];

  // effective address and alignment
  logic [ADDR_W-1:0] eff_addr;
  logic              misalign;

  always_comb begin
    if (mode64_i) begin
      eff_addr = req_addr_i;
    end else begin
      eff_addr = {{(ADDR_W-ADDR_HALF){1'b0}}, req_addr_i[ADDR_HALF-1:0]};
    end
  end
  assign misalign = |req_addr_i[ALIGN_BITS-1:0];

  // controller
  logic accept, cap_en, ld_fire, rsv_set, rsv_clr, rsv_match;

  lrsc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .req_valid_i (req_valid_i),
    .is_sc_i     (req_is_sc_i),
    .misalign_i  (misalign),
    .match_i     (rsv_match),
    .so_i        (so_flag_i),
    .mem_ack_i   (mem_ack_i),
    .ready_o     (req_ready_o),
    .accept_o    (accept),
    .cap_en_o    (cap_en),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .ld_fire_o   (ld_fire),
    .rsv_set_o   (rsv_set),
    .rsv_clr_o   (rsv_clr),
    .align_exc_o (align_exc_o),
    .ld_valid_o  (ld_valid_o),
    .sc_done_o   (sc_done_o),
    .sc_cr_o     (sc_cr_o)
  );

  // captured request
  logic [ADDR_W-1:0] cap_addr_q;
  logic [DATA_W-1:0] cap_wdata_q;
  logic              cap_dbl_q, cap_rev_q;
  logic [DATA_W-1:0] st_lane;

  lrsc_byte_lane #(.DATA_W(DATA_W)) u_st_lane (
    .dbl_i  (req_dbl_i),
    .rev_i  (req_rev_i),
    .data_i (req_wdata_i),
    .data_o (st_lane)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cap_addr_q  <= '0;
      cap_wdata_q <= '0;
      cap_dbl_q   <= 1'b0;
      cap_rev_q   <= 1'b0;
    end else if (cap_en) begin
      cap_addr_q  <= eff_addr;
      cap_wdata_q <= st_lane;
      cap_dbl_q   <= req_dbl_i;
      cap_rev_q   <= req_rev_i;
    end
  end

  assign mem_addr_o  = cap_addr_q;
  assign mem_wdata_o = cap_wdata_q;
  assign mem_dbl_o   = cap_dbl_q;

  // load result path
  logic [DATA_W-1:0] ld_lane;
  logic [DATA_W-1:0] ld_data_q;

  lrsc_byte_lane #(.DATA_W(DATA_W)) u_ld_lane (
    .dbl_i  (cap_dbl_q),
    .rev_i  (cap_rev_q),
    .data_i (mem_rdata_i),
    .data_o (ld_lane)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ld_data_q <= '0;
    end else if (ld_fire) begin
      ld_data_q <= ld_lane;
    end
  end
  assign ld_data_o = ld_data_q;

  // reservation
  lrsc_rsv_reg #(.ADDR_W(ADDR_W)) u_rsv (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .set_i      (rsv_set),
    .clr_i      (rsv_clr),
    .addr_set_i (cap_addr_q),
    .addr_cmp_i (eff_addr),
    .match_o    (rsv_match)
  );

  logic unused_accept;
  assign unused_accept = accept;

endmodule

// File: rtl/lrsc_reservation_sva.sv
module lrsc_reservation_sva #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_addr_lo,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ack_i,
  input logic              ld_valid_o,
  input logic              align_exc_o,
  input logic              sc_done_o,
  input logic [3:0]        sc_cr_o
);

  p_misalign_trap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_ready_o && (req_addr_lo != 2'b00)) |=>
      (align_exc_o && !mem_req_o && !ld_valid_o && !sc_done_o));

  p_cr_kept_on_trap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    align_exc_o |-> $stable(sc_cr_o));

  p_load_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid_o |-> $past(mem_ack_i && mem_req_o && !mem_we_o));

  p_success_wrote_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_done_o && sc_cr_o[1]) |-> $past(mem_ack_i && mem_req_o && mem_we_o));

  p_cr_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sc_done_o |-> (sc_cr_o[3:2] == 2'b00));

  p_busy_not_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o |-> !req_ready_o);

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ack_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

  p_one_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({align_exc_o, ld_valid_o, sc_done_o}));

endmodule

bind lrsc_reservation_unit lrsc_reservation_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .req_addr_lo (req_addr_i[1:0]),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_ack_i   (mem_ack_i),
  .ld_valid_o  (ld_valid_o),
  .align_exc_o (align_exc_o),
  .sc_done_o   (sc_done_o),
  .sc_cr_o     (sc_cr_o)
);

// File: tb/tb_lrsc_reservation_unit.sv
`timescale 1ns/1ps
module tb_lrsc_reservation_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mode64_i, so_flag_i, req_valid_i, req_is_sc_i, req_dbl_i, req_rev_i;
  logic [63:0] req_addr_i, req_wdata_i;
  logic        req_ready_o, mem_req_o, mem_we_o, mem_dbl_o;
  logic [63:0] mem_addr_o, mem_wdata_o, mem_rdata_i, ld_data_o;
  logic        mem_ack_i, ld_valid_o, align_exc_o, sc_done_o;
  logic [3:0]  sc_cr_o;

  always #2 clk = ~clk;

  lrsc_reservation_unit dut (
    .clk(clk), .rst_n(rst_n), .mode64_i(mode64_i), .so_flag_i(so_flag_i),
    .req_valid_i(req_valid_i), .req_ready_o(req_ready_o), .req_is_sc_i(req_is_sc_i),
    .req_dbl_i(req_dbl_i), .req_rev_i(req_rev_i), .req_addr_i(req_addr_i),
    .req_wdata_i(req_wdata_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_dbl_o(mem_dbl_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_ack_i(mem_ack_i), .mem_rdata_i(mem_rdata_i), .ld_valid_o(ld_valid_o),
    .ld_data_o(ld_data_o), .align_exc_o(align_exc_o), .sc_done_o(sc_done_o),
    .sc_cr_o(sc_cr_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  int cyc = 0;

  // bench reservation model
  bit          m_rsv_v = 1'b0;
  logic [63:0] m_rsv_a = '0;

  logic [7:0] mem [logic [63:0]];

  function automatic logic [7:0] mbyte(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [63:0] mem_fetch(input logic [63:0] a, input logic dbl);
    logic [63:0] r = '0;
    for (int i = 0; i < (dbl ? 8 : 4); i++) r = {r[55:0], mbyte(a + 64'(i))};
    return r;
  endfunction

  function automatic logic [63:0] lane(input logic [63:0] d, input logic dbl, input logic rev);
    logic [63:0] r = '0;
    if (!rev) return dbl ? d : {32'h0, d[31:0]};
    if (dbl) for (int i = 0; i < 8; i++) r[8*i +: 8] = d[8*(7-i) +: 8];
    else     for (int i = 0; i < 4; i++) r[8*i +: 8] = d[8*(3-i) +: 8];
    return r;
  endfunction

  // single-port memory model, one-cycle acknowledge
  always @(posedge clk) begin
    if (mem_req_o && !mem_ack_i) begin
      mem_ack_i <= 1'b1;
      if (mem_we_o) begin
        for (int i = 0; i < (mem_dbl_o ? 8 : 4); i++)
          mem[mem_addr_o + 64'(i)] = mem_dbl_o ? mem_wdata_o[8*(7-i) +: 8]
                                               : mem_wdata_o[8*(3-i) +: 8];
        wr_cnt++;
      end else begin
        mem_rdata_i <= mem_fetch(mem_addr_o, mem_dbl_o);
        rd_cnt++;
      end
    end else begin
      mem_ack_i <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // wait for a completion pulse, bounded
  task automatic wait_pulse(output bit got_ld, output bit got_sc);
    got_ld = 1'b0; got_sc = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (ld_valid_o || sc_done_o) begin
        got_ld = ld_valid_o; got_sc = sc_done_o;
        return;
      end
    end
  endtask

  task automatic do_op(input bit is_sc, input bit dbl, input bit rev, input bit m64,
                       input bit so, input logic [63:0] addr, input logic [63:0] wdata);
    logic [63:0] eff;
    logic [63:0] exp_ld;
    logic [3:0]  prev_cr;
    bit          mis, ok, got_ld, got_sc;
    int          wr0, rd0;
    eff     = m64 ? addr : {32'h0, addr[31:0]};
    mis     = (addr[1:0] != 2'b00);
    exp_ld  = lane(mem_fetch(eff, dbl), dbl, rev);
    ok      = m_rsv_v && (m_rsv_a == eff);
    @(negedge clk);
    prev_cr = sc_cr_o; wr0 = wr_cnt; rd0 = rd_cnt;
    chk("R9 ready before request", 64'(req_ready_o), 64'd1);
    req_valid_i = 1'b1; req_is_sc_i = is_sc; req_dbl_i = dbl; req_rev_i = rev;
    mode64_i = m64; so_flag_i = so; req_addr_i = addr; req_wdata_i = wdata;
    @(negedge clk);
    req_valid_i = 1'b0;
    so_flag_i   = ~so;                       // R10: later changes must not matter
    if (mis) begin
      chk("R1 exception pulse", 64'(align_exc_o), 64'd1);
      chk("R1 no memory request", 64'(mem_req_o), 64'd0);
      chk("R1 condition field kept", 64'(sc_cr_o), 64'(prev_cr));
      @(negedge clk);
      chk("R1 exception one cycle", 64'(align_exc_o), 64'd0);
      chk("R1 no memory traffic", 64'(wr_cnt + rd_cnt), 64'(wr0 + rd0));
      chk("R1 no completion", 64'({ld_valid_o, sc_done_o}), 64'd0);
    end else if (!is_sc) begin
      chk("R2 read issued", 64'({mem_req_o, mem_we_o}), 64'b10);
      chk("R7 read address", mem_addr_o, eff);
      chk("R9 busy not ready", 64'(req_ready_o), 64'd0);
      wait_pulse(got_ld, got_sc);
      chk("R2 load completion", 64'({got_ld, got_sc}), 64'b10);
      chk("R6 load data", ld_data_o, exp_ld);
      m_rsv_v = 1'b1; m_rsv_a = eff;
    end else if (ok) begin
      chk("R3 write issued", 64'({mem_req_o, mem_we_o}), 64'b11);
      chk("R7 write address", mem_addr_o, eff);
      chk("R6 write data", mem_wdata_o, lane(wdata, dbl, rev));
      wait_pulse(got_ld, got_sc);
      chk("R3 store completion", 64'({got_ld, got_sc}), 64'b01);
      chk("R10 success field", 64'(sc_cr_o), 64'({2'b00, 1'b1, so}));
      chk("R3 one write", 64'(wr_cnt), 64'(wr0 + 1));
      m_rsv_v = 1'b0;                        // R5
    end else begin
      chk("R4 immediate done", 64'(sc_done_o), 64'd1);
      chk("R4 failure field", 64'(sc_cr_o), 64'({3'b000, so}));
      chk("R4 no memory request", 64'(mem_req_o), 64'd0);
      @(negedge clk);
      chk("R4 no write", 64'(wr_cnt), 64'(wr0));
      m_rsv_v = 1'b0;                        // R5
    end
  endtask

  initial begin
    int seed;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; mem_ack_i = 1'b0; mem_rdata_i = '0;
    mode64_i = 1'b1; so_flag_i = 1'b0; req_valid_i = 1'b0; req_is_sc_i = 1'b0;
    req_dbl_i = 1'b0; req_rev_i = 1'b0; req_addr_i = '0; req_wdata_i = '0;
    repeat (3) @(negedge clk);
    chk("R9 not ready in reset", 64'(req_ready_o), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 reset ready", 64'(req_ready_o), 64'd1);
    chk("R9 reset outputs", 64'({mem_req_o, align_exc_o, ld_valid_o, sc_done_o}), 64'd0);
    chk("R9 reset field", 64'(sc_cr_o), 64'd0);

    // R9: no reservation after reset
    do_op(1, 0, 0, 1, 0, 64'h100, 64'h1111_2222);
    // R2/R3/R5 basic sequence, word big-endian
    do_op(0, 0, 0, 1, 0, 64'h100, 64'h0);
    do_op(1, 0, 0, 1, 1, 64'h100, 64'hDEAD_BEEF);
    do_op(1, 0, 0, 1, 0, 64'h100, 64'h1);      // R5 second SC fails
    do_op(0, 0, 0, 1, 0, 64'h100, 64'h0);      // read back written word
    // R1: traps between LR and SC leave reservation intact
    do_op(0, 1, 0, 1, 0, 64'h200, 64'h0);
    do_op(0, 1, 0, 1, 0, 64'h201, 64'h0);
    do_op(1, 0, 1, 1, 0, 64'h203, 64'h5);
    do_op(1, 1, 0, 1, 1, 64'h202, 64'h5);
    do_op(1, 1, 0, 1, 1, 64'h200, 64'h0123_4567_89AB_CDEF);
    // R6 byte-reversed forms
    do_op(0, 1, 1, 1, 0, 64'h200, 64'h0);
    do_op(0, 0, 1, 1, 0, 64'h204, 64'h0);
    do_op(1, 0, 1, 1, 0, 64'h204, 64'hAABB_CCDD);
    do_op(0, 0, 0, 1, 0, 64'h204, 64'h0);
    do_op(0, 1, 1, 1, 0, 64'h304, 64'h0);      // doubleword at 4 mod 8 is legal
    do_op(1, 1, 1, 1, 0, 64'h304, 64'h1122_3344_5566_7788);
    do_op(0, 1, 0, 1, 0, 64'h304, 64'h0);
    // R8 replacement
    do_op(0, 0, 0, 1, 0, 64'h400, 64'h0);
    do_op(0, 0, 0, 1, 0, 64'h408, 64'h0);
    do_op(1, 0, 0, 1, 0, 64'h400, 64'h9);
    do_op(0, 0, 0, 1, 0, 64'h400, 64'h0);
    do_op(0, 0, 0, 1, 0, 64'h408, 64'h0);
    do_op(1, 0, 0, 1, 1, 64'h408, 64'h9);
    // R7 address modes
    do_op(0, 0, 0, 0, 0, 64'h0000_0001_0000_0500, 64'h0);
    do_op(1, 0, 0, 0, 0, 64'h0000_0007_0000_0500, 64'h77);
    do_op(0, 0, 0, 1, 0, 64'h0000_0001_0000_0500, 64'h0);
    do_op(1, 0, 0, 1, 0, 64'h0000_0000_0000_0500, 64'h66);

    // constrained random mix on a small address pool
    for (int n = 0; n < 600; n++) begin
      logic [63:0] a;
      logic [63:0] d;
      bit          sc;
      a  = {31'h0, 1'($urandom_range(0, 1)), 32'h600 + 32'($urandom_range(0, 3)) * 4};
      if ($urandom_range(0, 7) == 0) a[1:0] = 2'($urandom_range(1, 3));
      d  = {$urandom, $urandom};
      sc = ($urandom_range(0, 1) == 1);
      do_op(sc, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a, d);
    end

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule